// File: doc/BRIEF.md
# Single-Level Shadow Register Save

This block keeps one saved copy of three core registers: the status flags, the working register and the bank-select register. When the core enters an interrupt of either priority, or executes a call that carries the fast mark, the block copies the live values of all three registers into its store. When the core executes a return that carries the fast mark, the block drives the saved copy back toward the register file for one cycle. A return without the fast mark leaves the block alone.

The store is exactly one level deep, and software cannot read or write it. A second capture always replaces the first. In particular, a high-priority interrupt that arrives while a low-priority handler is running overwrites the values the low-priority entry saved. Interrupt arbitration, priority logic and the register file are outside this block. It only sees event strobes and live register values.

Top module: `shadow_save_top`

## Requirements
- R1: After reset all three stored registers read as zero, and restore_vld is low until the first fast return.
- R2: A cycle with vec_hi high stores live_status, live_wreg and live_bank at that clock edge.
- R3: A cycle with vec_lo high stores the three live values at that clock edge.
- R4: A cycle with call_fast high stores the three live values at that clock edge.
- R5: A cycle with ret_fast high makes restore_vld high for exactly the following cycle, with rest_status, rest_wreg and rest_bank equal to the stored values.
- R6: A cycle with ret_plain high and ret_fast low does not raise restore_vld and does not change the stored values.
- R7: A vec_hi capture taken after a vec_lo capture, with no fast return between them, replaces the earlier values, so the next fast return yields the vec_hi values.
- R8: When a capture strobe and ret_fast are high in the same cycle, the restore output in the next cycle carries the contents held before that edge, and the store then holds the newly captured values.
- R9: While restore_vld is low, rest_status, rest_wreg and rest_bank are all zero.
- R10: A fast return does not empty the store, so a second fast return with no capture between yields the same values again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| live_status | input | DATA_W | Current status register value |
| live_wreg | input | DATA_W | Current working register value |
| live_bank | input | DATA_W | Current bank-select register value |
| vec_hi | input | 1 | Core vectors to a high-priority interrupt |
| vec_lo | input | 1 | Core vectors to a low-priority interrupt |
| call_fast | input | 1 | Call with the fast mark executes |
| ret_fast | input | 1 | Return with the fast mark executes |
| ret_plain | input | 1 | Return without the fast mark executes |
| rest_status | output | DATA_W | Restored status value |
| rest_wreg | output | DATA_W | Restored working register value |
| rest_bank | output | DATA_W | Restored bank-select value |
| restore_vld | output | 1 | One-cycle strobe marking valid restore data |

## Verification
The bench builds the block with the default DATA_W of 8. That width lets every field take values with bit 7 set and with all bits set, such as 0xFF and 0x80, so a lost upper bit or swapped fields show up in the restored data. With three distinct byte patterns per capture, any wiring of a live input to the wrong stored field gives a visible mismatch. Same-cycle capture-and-return and back-to-back nested captures are driven directly, which exercises the ordering between the store and the restore register.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

    // Number of core registers held in the shadow store.
    localparam int unsigned SHD_NREG = 3;

    // Field indices inside the packed register array.
    localparam int unsigned SHD_IDX_STATUS = 0;
    localparam int unsigned SHD_IDX_WREG   = 1;
    localparam int unsigned SHD_IDX_BANK   = 2;

    // Event classification for a single cycle.
    typedef enum logic [1:0] {
        SHD_EV_IDLE    = 2'b00,
        SHD_EV_CAPTURE = 2'b01,
        SHD_EV_RESTORE = 2'b10,
        SHD_EV_BOTH    = 2'b11
    } shd_event_e;

endpackage

// File: rtl/shadow_event_decode.sv
module shadow_event_decode
    import shadow_pkg::*;
(
    input  logic       vec_hi,
    input  logic       vec_lo,
    input  logic       call_fast,
    input  logic       ret_fast,
    input  logic       ret_plain,
    output shd_event_e ev_kind,
    output logic       do_capture,
    output logic       do_restore
);

    logic capture_any;
    logic restore_any;

    always_comb begin
        // Either interrupt priority or a fast call loads the store.
        capture_any = vec_hi | vec_lo | call_fast;
        // Only the fast mark restores; a plain return is deliberately unused.
        restore_any = ret_fast;
        unique case ({restore_any, capture_any})
            2'b01:   ev_kind = SHD_EV_CAPTURE;
            2'b10:   ev_kind = SHD_EV_RESTORE;
            2'b11:   ev_kind = SHD_EV_BOTH;
            default: ev_kind = SHD_EV_IDLE;
        endcase
    end

    always_comb begin
        do_capture = (ev_kind == SHD_EV_CAPTURE) || (ev_kind == SHD_EV_BOTH);
        do_restore = (ev_kind == SHD_EV_RESTORE) || (ev_kind == SHD_EV_BOTH);
    end

    logic unused_plain;
    assign unused_plain = ret_plain;

endmodule

// File: rtl/shadow_store.sv
module shadow_store
    import shadow_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             do_capture,
    input  logic [SHD_NREG-1:0][DATA_W-1:0]  live_regs,
    output logic [SHD_NREG-1:0][DATA_W-1:0]  held_regs
);

    typedef struct packed {
        logic [SHD_NREG-1:0][DATA_W-1:0] regs;
    } store_t;

    store_t st_d;
    store_t st_q;

    always_comb begin
        st_d = st_q;
        for (int unsigned i = 0; i < SHD_NREG; i++) begin
            if (do_capture) begin
                st_d.regs[i] = live_regs[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_regs = st_q.regs;

endmodule

// File: rtl/shadow_restore_port.sv
module shadow_restore_port
    import shadow_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             do_restore,
    input  logic [SHD_NREG-1:0][DATA_W-1:0]  held_regs,
    output logic [SHD_NREG-1:0][DATA_W-1:0]  out_regs,
    output logic                             out_vld
);

    typedef struct packed {
        logic                            vld;
        logic [SHD_NREG-1:0][DATA_W-1:0] data;
    } port_t;

    port_t pt_d;
    port_t pt_q;

    always_comb begin
        pt_d.vld = do_restore;
        // The held value is sampled before the store updates at this edge,
        // so a same-cycle capture never leaks into the restore data.
        for (int unsigned i = 0; i < SHD_NREG; i++) begin
            pt_d.data[i] = do_restore ? held_regs[i] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_q <= '0;
        end else begin
            pt_q <= pt_d;
        end
    end

    assign out_regs = pt_q.data;
    assign out_vld  = pt_q.vld;

endmodule

// File: rtl/shadow_save_top.sv
module shadow_save_top
    import shadow_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] live_status,
    input  logic [DATA_W-1:0] live_wreg,
    input  logic [DATA_W-1:0] live_bank,
    input  logic              vec_hi,
    input  logic              vec_lo,
    input  logic              call_fast,
    input  logic              ret_fast,
    input  logic              ret_plain,
    output logic [DATA_W-1:0] rest_status,
    output logic [DATA_W-1:0] rest_wreg,
    output logic [DATA_W-1:0] rest_bank,
    output logic              restore_vld
);

    logic [SHD_NREG-1:0][DATA_W-1:0] live_regs;
    logic [SHD_NREG-1:0][DATA_W-1:0] held_regs;
    logic [SHD_NREG-1:0][DATA_W-1:0] out_regs;
    shd_event_e                      ev_kind;
    logic                            do_capture;
    logic                            do_restore;

    always_comb begin
        live_regs                 = '0;
        live_regs[SHD_IDX_STATUS] = live_status;
        live_regs[SHD_IDX_WREG]   = live_wreg;
        live_regs[SHD_IDX_BANK]   = live_bank;
    end

    shadow_event_decode u_decode (
        .vec_hi     (vec_hi),
        .vec_lo     (vec_lo),
        .call_fast  (call_fast),
        .ret_fast   (ret_fast),
        .ret_plain  (ret_plain),
        .ev_kind    (ev_kind),
        .do_capture (do_capture),
        .do_restore (do_restore)
    );

    shadow_store #(.DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_capture (do_capture),
        .live_regs  (live_regs),
        .held_regs  (held_regs)
    );

    shadow_restore_port #(.DATA_W(DATA_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_restore (do_restore),
        .held_regs  (held_regs),
        .out_regs   (out_regs),
        .out_vld    (restore_vld)
    );

    assign rest_status = out_regs[SHD_IDX_STATUS];
    assign rest_wreg   = out_regs[SHD_IDX_WREG];
    assign rest_bank   = out_regs[SHD_IDX_BANK];

    shd_event_e unused_kind;
    assign unused_kind = ev_kind;

endmodule

// File: rtl/shadow_save_checker.sv
module shadow_save_checker
    import shadow_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [DATA_W-1:0]                live_status,
    input logic [DATA_W-1:0]                live_wreg,
    input logic [DATA_W-1:0]                live_bank,
    input logic                             vec_hi,
    input logic                             vec_lo,
    input logic                             call_fast,
    input logic                             ret_fast,
    input logic                             ret_plain,
    input logic [DATA_W-1:0]                rest_status,
    input logic [DATA_W-1:0]                rest_wreg,
    input logic [DATA_W-1:0]                rest_bank,
    input logic                             restore_vld,
    input logic [SHD_NREG-1:0][DATA_W-1:0]  held_regs
);

    AST_HI_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_hi |=> held_regs == {$past(live_bank), $past(live_wreg), $past(live_status)}); // R2
    AST_LO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_lo |=> held_regs == {$past(live_bank), $past(live_wreg), $past(live_status)}); // R3
    AST_CALL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        call_fast |=> held_regs == {$past(live_bank), $past(live_wreg), $past(live_status)}); // R4
    AST_FAST_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_fast |=> restore_vld); // R5
    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        restore_vld |-> $past(ret_fast)); // R5
    AST_PLAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_plain && !ret_fast) |=> !restore_vld); // R6
    AST_PLAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_plain && !ret_fast && !vec_hi && !vec_lo && !call_fast) |=> $stable(held_regs)); // R6
    AST_OLD_DATA_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        ret_fast |=> {rest_bank, rest_wreg, rest_status} == $past(held_regs)); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !restore_vld |-> (rest_status == '0 && rest_wreg == '0 && rest_bank == '0)); // R9

endmodule

bind shadow_save_top shadow_save_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .live_status (live_status),
    .live_wreg   (live_wreg),
    .live_bank   (live_bank),
    .vec_hi      (vec_hi),
    .vec_lo      (vec_lo),
    .call_fast   (call_fast),
    .ret_fast    (ret_fast),
    .ret_plain   (ret_plain),
    .rest_status (rest_status),
    .rest_wreg   (rest_wreg),
    .rest_bank   (rest_bank),
    .restore_vld (restore_vld),
    .held_regs   (held_regs)
);

// File: tb/tb_shadow_save_top.sv
`timescale 1ns/1ps
module tb_shadow_save_top;

    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] live_status, live_wreg, live_bank;
    logic         vec_hi, vec_lo, call_fast, ret_fast, ret_plain;
    logic [W-1:0] rest_status, rest_wreg, rest_bank;
    logic         restore_vld;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    shadow_save_top #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .live_status(live_status), .live_wreg(live_wreg), .live_bank(live_bank),
        .vec_hi(vec_hi), .vec_lo(vec_lo), .call_fast(call_fast),
        .ret_fast(ret_fast), .ret_plain(ret_plain),
        .rest_status(rest_status), .rest_wreg(rest_wreg), .rest_bank(rest_bank),
        .restore_vld(restore_vld)
    );

    // Advance one edge; inputs change 1 ns after it, outputs are read there too.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        vec_hi = 0; vec_lo = 0; call_fast = 0; ret_fast = 0; ret_plain = 0;
    endtask

    task automatic set_live(input logic [W-1:0] s, input logic [W-1:0] w, input logic [W-1:0] b);
        live_status = s; live_wreg = w; live_bank = b;
    endtask

    task automatic expect_out(input string req, input logic vld,
                              input logic [W-1:0] s, input logic [W-1:0] w, input logic [W-1:0] b);
        checks++;
        if (restore_vld !== vld || rest_status !== s || rest_wreg !== w || rest_bank !== b) begin
            failures++;
            $display("FAIL %s: got vld=%0b s=%02h w=%02h b=%02h expected vld=%0b s=%02h w=%02h b=%02h",
                     req, restore_vld, rest_status, rest_wreg, rest_bank, vld, s, w, b);
        end
    endtask

    // Issue a fast return and check the one-cycle strobe that follows.
    task automatic fast_return_check(input string req,
                                     input logic [W-1:0] s, input logic [W-1:0] w, input logic [W-1:0] b);
        idle(); ret_fast = 1;
        step();
        idle();
        expect_out(req, 1'b1, s, w, b);
        step();
        expect_out({req, " strobe ends"}, 1'b0, '0, '0, '0);
    endtask

    task automatic capture(input int kind, input logic [W-1:0] s, input logic [W-1:0] w, input logic [W-1:0] b);
        idle(); set_live(s, w, b);
        case (kind)
            0: vec_hi = 1;
            1: vec_lo = 1;
            default: call_fast = 1;
        endcase
        step();
        idle(); set_live(8'h11, 8'h22, 8'h33); // live values move on afterwards
    endtask

    task automatic t_reset();
        idle(); set_live('0, '0, '0);
        rst_n = 0;
        step(); step();
        rst_n = 1;
        expect_out("R1 outputs after reset", 1'b0, '0, '0, '0);
        fast_return_check("R1 store cleared", 8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_captures();
        capture(0, 8'hA5, 8'h3C, 8'h0F);
        fast_return_check("R2 high vector capture", 8'hA5, 8'h3C, 8'h0F);
        capture(1, 8'h80, 8'h7F, 8'h01);
        fast_return_check("R3 low vector capture", 8'h80, 8'h7F, 8'h01);
        capture(2, 8'hFF, 8'h00, 8'hC3);
        fast_return_check("R4 fast call capture", 8'hFF, 8'h00, 8'hC3);
    endtask

    task automatic t_plain_return();
        capture(2, 8'h5A, 8'hE1, 8'h96);
        idle(); ret_plain = 1;
        step();
        idle();
        expect_out("R6 plain return no strobe", 1'b0, '0, '0, '0);
        step();
        expect_out("R9 idle outputs zero", 1'b0, '0, '0, '0);
        fast_return_check("R6 store unchanged by plain return", 8'h5A, 8'hE1, 8'h96);
    endtask

    task automatic t_nested();
        capture(1, 8'h12, 8'h34, 8'h56);
        capture(0, 8'h9A, 8'hBC, 8'hDE);
        fast_return_check("R7 high overwrites low", 8'h9A, 8'hBC, 8'hDE);
    endtask

    task automatic t_same_cycle();
        capture(0, 8'h01, 8'h02, 8'h03);
        idle(); set_live(8'hF0, 8'hE0, 8'hD0);
        vec_lo = 1; ret_fast = 1;
        step();
        idle();
        expect_out("R8 old contents on restore", 1'b1, 8'h01, 8'h02, 8'h03);
        step();
        fast_return_check("R8 store holds new capture", 8'hF0, 8'hE0, 8'hD0);
    endtask

    task automatic t_repeat_return();
        capture(2, 8'h44, 8'h88, 8'hCC);
        fast_return_check("R10 first fast return", 8'h44, 8'h88, 8'hCC);
        fast_return_check("R10 second fast return", 8'h44, 8'h88, 8'hCC);
        // Back-to-back fast returns keep the strobe high for both cycles.
        idle(); ret_fast = 1;
        step();
        expect_out("R5 back-to-back first", 1'b1, 8'h44, 8'h88, 8'hCC);
        step();
        idle();
        expect_out("R5 back-to-back second", 1'b1, 8'h44, 8'h88, 8'hCC);
        step();
        expect_out("R5 strobe drops", 1'b0, '0, '0, '0);
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        idle(); set_live('0, '0, '0);
        #1;
        t_reset();
        t_captures();
        t_plain_return();
        t_nested();
        t_same_cycle();
        t_repeat_return();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule